// File: doc/BRIEF.md
# Programmable Counter Array Timebase

This block is the shared 16-bit timebase behind a set of capture/compare channels. The count is kept as a low byte and a high byte. The high byte takes the carry out of the low byte. The count advances from one of four sources, picked by a two-bit source field in the mode byte:

- the system tick, one count per tick;
- the system tick, three counts per tick;
- a timer-0 overflow strobe;
- falling edges on an external count pin.

Counting runs only while the run bit is set. Counting can also pause while the host processor is idle.

The host reaches the block through a small write port. That port has five addresses: mode byte, control byte, counter low byte, counter high byte, and a single-bit run address. The block drives four things:

- the count;
- a one-cycle strobe on each low-byte wrap, which channels in PWM mode use to reload their compare value;
- a sticky overflow flag;
- an overflow interrupt request.

Timer and pin events that arrive while counting is held are kept in small pending counters. They are applied one per cycle once counting resumes, so none are lost across a short stop.

Top module: `pca_timebase`

## Requirements
- R1: The count changes only while the run bit is 1. Two writes set or clear it: bit 0 of a write to address 4, or bit 6 of a write to the control byte at address 1.
- R2: When mode bit 7 (idle stop) is 1 and `host_idle` is high, the count holds. With mode bit 7 at 0, `host_idle` has no effect.
- R3: With source field 00, the count rises by one on each cycle in which `sys_tick` is high.
- R4: With source field 01, the count rises by three on each cycle in which `sys_tick` is high.
- R5: With source field 10, each `t0_ovf` pulse adds one. Pulses seen while counting is held are stored, saturating at 15, and applied one per cycle once counting resumes. `sys_tick` has no effect in this mode.
- R6: With source field 11, each falling edge of `ext_cnt_in` adds one. The pin passes through two synchroniser flops, so a fall driven before clock edge k shows in the count after edge k+2. Rising edges add nothing.
- R7: A mode write whose source field differs from the current one discards all stored timer and pin events.
- R8: The high byte increments when the low byte wraps. `lo_wrap` is high for exactly the one cycle in which the wrapped count is first shown.
- R9: A wrap of the full 16-bit count sets `ovf_flag`, and it then stays set. A control-byte write loads the flag from data bit 7, and a wrap in the same cycle wins. `ovf_irq` is high when the flag and mode bit 0 (interrupt enable) are both 1.
- R10: Writes to address 2 (low byte) and address 3 (high byte) show on the count after the next clock edge. Such a write cancels any count step in that same cycle, and the other byte keeps its value.
- R11: The mode byte at address 0 holds the interrupt enable in bit 0, the source field in bits 2:1, the watchdog enable in bit 6 and the idle stop in bit 7. `wdog_en` shows mode bit 6. All registers reset to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sys_tick | input | 1 | System tick, one-cycle pulse |
| t0_ovf | input | 1 | Timer-0 overflow strobe |
| ext_cnt_in | input | 1 | External count pin, asynchronous |
| host_idle | input | 1 | Host is in idle state |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address: 0 mode, 1 control, 2 low, 3 high, 4 run bit |
| wr_data | input | 8 | Register write data |
| count | output | 16 | Current count value |
| lo_wrap | output | 1 | Low-byte wrap strobe for PWM reload |
| ovf_flag | output | 1 | Sticky 16-bit overflow flag |
| ovf_irq | output | 1 | Overflow interrupt request |
| wdog_en | output | 1 | Watchdog enable bit from the mode byte |

## Verification
Register writes, tick-driven steps and timer-strobe steps all show on the outputs one cycle after the input cycle. The `lo_wrap` strobe and the overflow flag rise in that same cycle. A stored event drains in the cycle after run is restored. A pin fall takes three cycles because of the synchroniser and the edge flop.

Each stimulus task pushes its expected results into a scoreboard queue, tagged with the cycle number at which they are due. A monitor samples the outputs mid-cycle and compares only the items due in the current cycle. A late or early change is therefore caught as a mismatch at the cycle where the value was due.

// File: rtl/pcatb_pkg.sv
package pcatb_pkg;

  // Count source selection (mode byte bits 2:1).
  typedef enum logic [1:0] {
    SRC_TICK  = 2'b00,
    SRC_TICK3 = 2'b01,
    SRC_T0    = 2'b10,
    SRC_EXT   = 2'b11
  } cnt_src_e;

  // Register addresses.
  localparam logic [2:0] A_MODE = 3'd0;
  localparam logic [2:0] A_CTRL = 3'd1;
  localparam logic [2:0] A_LO   = 3'd2;
  localparam logic [2:0] A_HI   = 3'd3;
  localparam logic [2:0] A_RUN  = 3'd4;

  // Bit positions in the mode byte.
  localparam int MB_IRQEN = 0;
  localparam int MB_SEL   = 1;
  localparam int MB_WDOG  = 6;
  localparam int MB_IDLE  = 7;

  // Bit positions in the control byte.
  localparam int CB_RUN  = 6;
  localparam int CB_FLAG = 7;

  typedef struct packed {
    logic     idle_stop;
    logic     wdog;
    logic     irq_en;
    cnt_src_e sel;
  } mode_t;

endpackage

// File: rtl/pcatb_fall_sync.sv
// Synchronises an asynchronous pin and flags its falling edges.
module pcatb_fall_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic fall
);
  // sh[0..STAGES-1] are the synchroniser flops; sh[STAGES] holds the previous value.
  logic [STAGES:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '1;
    else        sh <= {sh[STAGES-1:0], pin};
  end

  assign fall = sh[STAGES] & ~sh[STAGES-1];
endmodule

// File: rtl/pcatb_pend.sv
// Saturating store of events not yet applied, drained one per cycle.
module pcatb_pend #(
  parameter int PEND_W = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic event_i,
  input  logic take,
  output logic go
);
  localparam logic [PEND_W-1:0] PEND_MAX = '1;

  logic [PEND_W-1:0] pend_q;

  assign go = take & (event_i | (pend_q != '0));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
    end else if (clear) begin
      pend_q <= '0;                             // R7
    end else begin
      case ({event_i, go})
        2'b10:   if (pend_q != PEND_MAX) pend_q <= pend_q + 1'b1;
        2'b01:   pend_q <= pend_q - 1'b1;
        default: pend_q <= pend_q;
      endcase
    end
  end
endmodule

// File: rtl/pcatb_counter.sv
// Two-byte count register with a step adder and byte-write override.
module pcatb_counter #(
  parameter int CNT_W  = 16,
  parameter int STEP_W = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [STEP_W-1:0]     step,
  input  logic                  wr_lo,
  input  logic                  wr_hi,
  input  logic [CNT_W/2-1:0]    wr_byte,
  output logic [CNT_W-1:0]      count,
  output logic                  lo_wrap,
  output logic                  ovf_evt
);
  localparam int BYTE_W = CNT_W / 2;
  localparam int SUM_W  = CNT_W + 1;
  localparam int LSUM_W = BYTE_W + 1;

  function automatic logic [SUM_W-1:0] bump(logic [CNT_W-1:0] v, logic [STEP_W-1:0] s);
    return {1'b0, v} + SUM_W'(s);
  endfunction

  function automatic logic lo_carry(logic [BYTE_W-1:0] lo, logic [STEP_W-1:0] s);
    logic [LSUM_W-1:0] t;
    t = {1'b0, lo} + LSUM_W'(s);
    return t[BYTE_W];
  endfunction

  logic [CNT_W-1:0] cnt_q;
  logic             wrap_q;
  logic [SUM_W-1:0] sum;
  logic             any_wr;
  logic             wrap_now;

  always_comb begin
    sum      = bump(cnt_q, step);
    any_wr   = wr_lo | wr_hi;
    wrap_now = !any_wr && lo_carry(cnt_q[BYTE_W-1:0], step);   // R8
    ovf_evt  = !any_wr && sum[CNT_W];                          // R9
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      wrap_q <= 1'b0;
    end else begin
      wrap_q <= wrap_now;
      if (any_wr) begin                                        // R10
        if (wr_lo) cnt_q[BYTE_W-1:0]     <= wr_byte;
        if (wr_hi) cnt_q[CNT_W-1:BYTE_W] <= wr_byte;
      end else begin
        cnt_q <= sum[CNT_W-1:0];
      end
    end
  end

  assign count   = cnt_q;
  assign lo_wrap = wrap_q;
endmodule

// File: rtl/pca_timebase.sv
module pca_timebase
  import pcatb_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int TICK_MULT = 3,
  parameter int PEND_W    = 4,
  parameter int SYNC_N    = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sys_tick,
  input  logic               t0_ovf,
  input  logic               ext_cnt_in,
  input  logic               host_idle,
  input  logic               wr_en,
  input  logic [2:0]         wr_addr,
  input  logic [CNT_W/2-1:0] wr_data,
  output logic [CNT_W-1:0]   count,
  output logic               lo_wrap,
  output logic               ovf_flag,
  output logic               ovf_irq,
  output logic               wdog_en
);
  localparam int BYTE_W = CNT_W / 2;
  localparam int STEP_W = $clog2(TICK_MULT + 1);
  localparam int N_SRC  = 2;   // sources that store pending events

  mode_t mode_q;
  logic  run_q;
  logic  flag_q;

  // Named internal events, also observed by the checker.
  logic              wr_mode, wr_ctrl, wr_lo, wr_hi, wr_run;
  logic              sel_change;
  logic              adv;
  logic              idle_stop;
  logic [1:0]        cur_sel;
  logic              cnt_wr;
  logic              ext_fall;
  logic              ovf_evt;
  logic [STEP_W-1:0] step;
  logic [N_SRC-1:0]  src_evt, src_take, src_go;

  function automatic logic [STEP_W-1:0] pick_step(cnt_src_e s, logic tick, logic [N_SRC-1:0] go);
    case (s)
      SRC_TICK:  return STEP_W'(tick);                           // R3
      SRC_TICK3: return tick ? STEP_W'(TICK_MULT) : '0;          // R4
      SRC_T0:    return STEP_W'(go[0]);                          // R5
      default:   return STEP_W'(go[1]);                          // R6
    endcase
  endfunction

  assign wr_mode    = wr_en && (wr_addr == A_MODE);
  assign wr_ctrl    = wr_en && (wr_addr == A_CTRL);
  assign wr_lo      = wr_en && (wr_addr == A_LO);
  assign wr_hi      = wr_en && (wr_addr == A_HI);
  assign wr_run     = wr_en && (wr_addr == A_RUN);
  assign sel_change = wr_mode && (wr_data[MB_SEL+1:MB_SEL] != mode_q.sel);
  assign idle_stop  = mode_q.idle_stop;
  assign cur_sel    = mode_q.sel;
  assign adv        = run_q && !(idle_stop && host_idle);        // R1 R2
  assign cnt_wr     = wr_lo | wr_hi;

  pcatb_fall_sync #(.STAGES(SYNC_N)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .pin  (ext_cnt_in),
    .fall (ext_fall)
  );

  assign src_evt     = {ext_fall, t0_ovf};
  assign src_take[0] = adv && !cnt_wr && (mode_q.sel == SRC_T0);
  assign src_take[1] = adv && !cnt_wr && (mode_q.sel == SRC_EXT);

  for (genvar g = 0; g < N_SRC; g++) begin : g_pend
    pcatb_pend #(.PEND_W(PEND_W)) u_pend (
      .clk    (clk),
      .rst_n  (rst_n),
      .clear  (sel_change),
      .event_i(src_evt[g]),
      .take   (src_take[g]),
      .go     (src_go[g])
    );
  end

  assign step = adv ? pick_step(mode_q.sel, sys_tick, src_go) : '0;

  pcatb_counter #(.CNT_W(CNT_W), .STEP_W(STEP_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .step   (step),
    .wr_lo  (wr_lo),
    .wr_hi  (wr_hi),
    .wr_byte(wr_data),
    .count  (count),
    .lo_wrap(lo_wrap),
    .ovf_evt(ovf_evt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      run_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      if (wr_mode) begin                                          // R11
        mode_q.irq_en    <= wr_data[MB_IRQEN];
        mode_q.sel       <= cnt_src_e'(wr_data[MB_SEL+1:MB_SEL]);
        mode_q.wdog      <= wr_data[MB_WDOG];
        mode_q.idle_stop <= wr_data[MB_IDLE];
      end
      if (wr_run)       run_q <= wr_data[0];                      // R1
      else if (wr_ctrl) run_q <= wr_data[CB_RUN];
      if (ovf_evt)      flag_q <= 1'b1;                           // R9
      else if (wr_ctrl) flag_q <= wr_data[CB_FLAG];
    end
  end

  assign ovf_flag = flag_q;
  assign ovf_irq  = flag_q & mode_q.irq_en;
  assign wdog_en  = mode_q.wdog;
endmodule

// File: rtl/pcatb_chk.sv
module pcatb_chk #(
  parameter int CNT_W     = 16,
  parameter int TICK_MULT = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               wr_en,
  input logic [2:0]         wr_addr,
  input logic [CNT_W/2-1:0] wr_data,
  input logic               sys_tick,
  input logic               host_idle,
  input logic               run_q,
  input logic               idle_stop,
  input logic               adv,
  input logic [1:0]         cur_sel,
  input logic [CNT_W-1:0]   count,
  input logic               lo_wrap,
  input logic               ovf_flag,
  input logic               ovf_irq
);
  localparam int BYTE_W = CNT_W / 2;

  p_halt_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !wr_en) |=> $stable(count));

  p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && idle_stop && host_idle && !wr_en) |=> $stable(count));

  p_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && cur_sel == 2'b00 && sys_tick && !wr_en) |=> count == $past(count) + CNT_W'(1));

  p_triple_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && cur_sel == 2'b01 && sys_tick && !wr_en) |=> count == $past(count) + CNT_W'(TICK_MULT));

  p_carry_r8: assert property (@(posedge clk) disable iff (!rst_n)
    lo_wrap |-> count[BYTE_W-1:0] < BYTE_W'(TICK_MULT));

  p_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ovf_flag) && !$past(wr_en)) |-> count < CNT_W'(TICK_MULT));

  p_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_irq |-> ovf_flag);

  p_wrlo_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 3'd2) |=> count[BYTE_W-1:0] == $past(wr_data));
endmodule

bind pca_timebase pcatb_chk #(.CNT_W(CNT_W), .TICK_MULT(TICK_MULT)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_en    (wr_en),
  .wr_addr  (wr_addr),
  .wr_data  (wr_data),
  .sys_tick (sys_tick),
  .host_idle(host_idle),
  .run_q    (run_q),
  .idle_stop(idle_stop),
  .adv      (adv),
  .cur_sel  (cur_sel),
  .count    (count),
  .lo_wrap  (lo_wrap),
  .ovf_flag (ovf_flag),
  .ovf_irq  (ovf_irq)
);

// File: tb/pca_timebase_test.sv
module pca_timebase_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sys_tick = 1'b0, t0_ovf = 1'b0, ext_cnt_in = 1'b1, host_idle = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [15:0] count;
  logic        lo_wrap, ovf_flag, ovf_irq, wdog_en;

  always #5 clk = ~clk;   // 100 MHz

  pca_timebase uut (
    .clk(clk), .rst_n(rst_n), .sys_tick(sys_tick), .t0_ovf(t0_ovf),
    .ext_cnt_in(ext_cnt_in), .host_idle(host_idle), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .count(count), .lo_wrap(lo_wrap),
    .ovf_flag(ovf_flag), .ovf_irq(ovf_irq), .wdog_en(wdog_en)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int          kind;   // 0 count, 1 lo_wrap, 2 ovf_flag, 3 ovf_irq, 4 wdog_en
    int          due;
    logic [15:0] val;
    string       req;
  } item_t;

  item_t sbq[$];
  int    checks = 0;
  int    errors = 0;
  bit    done = 0;

  function automatic logic [15:0] observe(int kind);
    case (kind)
      0:       return count;
      1:       return {15'd0, lo_wrap};
      2:       return {15'd0, ovf_flag};
      3:       return {15'd0, ovf_irq};
      default: return {15'd0, wdog_en};
    endcase
  endfunction

  // Driver side: queue an expected value due `dly` cycles from now.
  task automatic expect_in(int kind, logic [15:0] val, string req, int dly);
    item_t it;
    it.kind = kind; it.due = cyc + dly; it.val = val; it.req = req;
    sbq.push_back(it);
  endtask

  task automatic expect_now(int kind, logic [15:0] val, string req);
    expect_in(kind, val, req, 0);
  endtask

  // Monitor: mid-cycle, compare every item that is due.
  initial begin
    forever begin
      @(negedge clk); #2;
      for (int i = sbq.size() - 1; i >= 0; i--) begin
        if (sbq[i].due <= cyc) begin
          logic [15:0] act;
          act = observe(sbq[i].kind);
          checks++;
          if (act !== sbq[i].val || sbq[i].due < cyc) begin
            errors++;
            $display("FAIL %s kind=%0d cycle=%0d actual=%h expected=%h",
                     sbq[i].req, sbq[i].kind, cyc, act, sbq[i].val);
          end
          sbq.delete(i);
        end
      end
    end
  end

  task automatic wr(logic [2:0] a, logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic tick(int n);
    for (int i = 0; i < n; i++) begin
      sys_tick = 1'b1;
      @(negedge clk);
    end
    sys_tick = 1'b0;
  endtask

  task automatic t0_pulse(int n);
    for (int i = 0; i < n; i++) begin
      t0_ovf = 1'b1;
      @(negedge clk);
    end
    t0_ovf = 1'b0;
  endtask

  task automatic idle_cycles(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11: all registers reset to zero
    expect_now(0, 16'h0000, "R11");
    expect_now(2, 16'h0, "R11");
    expect_now(3, 16'h0, "R11");
    expect_now(4, 16'h0, "R11");
    expect_now(1, 16'h0, "R11");

    // R10 byte writes; R1 no counting while stopped
    wr(3'd2, 8'h10);
    wr(3'd3, 8'h20);
    expect_now(0, 16'h2010, "R10");
    tick(3);
    expect_now(0, 16'h2010, "R1");

    // R1 run through address 4, then control byte bit 6
    wr(3'd4, 8'h01);
    tick(5);
    expect_now(0, 16'h2015, "R3");
    wr(3'd1, 8'h00);
    tick(3);
    expect_now(0, 16'h2015, "R1");
    wr(3'd1, 8'h40);
    tick(1);
    expect_now(0, 16'h2016, "R1");

    // R2 idle stop
    wr(3'd0, 8'h80);
    host_idle = 1'b1;
    tick(4);
    expect_now(0, 16'h2016, "R2");
    host_idle = 1'b0;
    tick(2);
    expect_now(0, 16'h2018, "R2");
    wr(3'd0, 8'h00);
    host_idle = 1'b1;
    tick(2);
    expect_now(0, 16'h201A, "R2");
    host_idle = 1'b0;

    // R4 triple step
    wr(3'd0, 8'h02);
    tick(2);
    expect_now(0, 16'h2020, "R4");

    // R8 low-byte wrap carries into the high byte, one-cycle strobe
    wr(3'd2, 8'hFE);
    expect_now(0, 16'h20FE, "R10");
    tick(1);
    expect_now(0, 16'h2101, "R8");
    expect_now(1, 16'h1, "R8");
    expect_in(1, 16'h0, "R8", 1);
    expect_in(0, 16'h2101, "R8", 1);
    idle_cycles(1);

    // R10 a byte write cancels the same-cycle step
    wr(3'd0, 8'h00);
    sys_tick = 1'b1;
    wr(3'd3, 8'h55);
    sys_tick = 1'b0;
    expect_now(0, 16'h5501, "R10");
    tick(1);
    expect_now(0, 16'h5502, "R3");

    // R9 overflow flag and interrupt
    wr(3'd0, 8'h01);
    wr(3'd3, 8'hFF);
    wr(3'd2, 8'hFF);
    expect_now(2, 16'h0, "R9");
    tick(1);
    expect_now(0, 16'h0000, "R9");
    expect_now(2, 16'h1, "R9");
    expect_now(3, 16'h1, "R9");
    expect_now(1, 16'h1, "R8");
    tick(2);
    expect_now(0, 16'h0002, "R9");
    expect_now(2, 16'h1, "R9");
    wr(3'd0, 8'h00);
    expect_now(3, 16'h0, "R9");
    expect_now(2, 16'h1, "R9");
    wr(3'd1, 8'h40);
    expect_now(2, 16'h0, "R9");

    // R5 timer-0 source, stored events drain after restart
    wr(3'd0, 8'h04);
    t0_pulse(3);
    expect_now(0, 16'h0005, "R5");
    tick(2);
    expect_now(0, 16'h0005, "R5");
    wr(3'd4, 8'h00);
    t0_pulse(2);
    expect_now(0, 16'h0005, "R5");
    wr(3'd4, 8'h01);
    expect_now(0, 16'h0005, "R5");
    expect_in(0, 16'h0006, "R5", 1);
    expect_in(0, 16'h0007, "R5", 2);
    expect_in(0, 16'h0007, "R5", 3);
    idle_cycles(3);

    // R7 a source change discards stored events
    wr(3'd4, 8'h00);
    t0_pulse(3);
    wr(3'd0, 8'h06);
    wr(3'd0, 8'h04);
    wr(3'd4, 8'h01);
    idle_cycles(3);
    expect_now(0, 16'h0007, "R7");

    // R6 falling edges of the external pin, three-cycle latency
    wr(3'd0, 8'h06);
    ext_cnt_in = 1'b0;
    expect_in(0, 16'h0007, "R6", 2);
    expect_in(0, 16'h0008, "R6", 3);
    idle_cycles(4);
    ext_cnt_in = 1'b1;
    idle_cycles(4);
    expect_now(0, 16'h0008, "R6");
    ext_cnt_in = 1'b0;
    idle_cycles(3);
    expect_now(0, 16'h0009, "R6");

    // R11 watchdog enable bit
    wr(3'd0, 8'h40);
    expect_now(4, 16'h1, "R11");

    idle_cycles(4);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule